// File: doc/BRIEF.md
# Shared-Interrupt Distributor Register Front-End

This block is the programming face of a shared-peripheral interrupt distributor. A host reaches it through a 32-bit word-wide read/write port. Behind the port sit the per-interrupt enable, pending, priority and trigger-type state for up to 1024 interrupt identifiers. The block also answers a set of fixed words: control, capability, identification and peripheral ID. Features that are not built answer as all-zero or all-one words, and writes to them are dropped.

The first 32 identifiers are private to each processor and are handled elsewhere. In every per-interrupt array their slots read zero and ignore writes. Only identifiers 32 to NUM_IRQ-1 hold state here. Two outputs face the delivery logic. One is the global group-1 enable. The other is one request line per interrupt, which is high while that interrupt is pending, enabled, and group 1 is on. Priority arbitration and delivery to processors happen downstream of this block.

Top module: `irq_dist_regs`

## Requirements
- R1: The control word at offset 0x000 keeps the group-1 enable in bit 1, which software can read and write. Bits 4 and 6 always read 1, and writes cannot clear them. Bit 0, the group-0 enable, always reads 0 even after a 1 is written to it. The `grp1_en` output follows bit 1.
- R2: The capability word at 0x004 holds min(NUM_IRQ,1024)/32−1 in bits 4:0 and the value 9 in bits 23:19. All other bits read 0. Writes are ignored.
- R3: The identification word at 0x008 reads the parameter IDENT_WORD. Writes are ignored.
- R4: Every word from 0x080 to 0x0FF (interrupt group) reads 0xFFFFFFFF. Writes are ignored.
- R5: Enable state has a set window at 0x100 and a clear window at 0x180. Bit b of word w stands for interrupt 32w+b. Writing 1 to a bit in the set window sets that enable, and writing 1 in the clear window clears it. Bits written as 0 have no effect. A read of either window returns the current enables.
- R6: Pending state works the same way, with its set window at 0x200 and its clear window at 0x280.
- R7: Certain words read zero and ignore writes. These are word 0 of the four enable and pending windows, words 0–7 of the priority array, and words 0–1 of the trigger array, which together cover interrupts 0–31. The same holds for any array word whose interrupts lie at or above NUM_IRQ. Request lines 31:0 are always 0.
- R8: The priority array starts at 0x400. Byte k of word w is the 8-bit priority of interrupt 4w+k. Each byte reads back exactly as written.
- R9: The trigger array starts at 0xC00. Interrupt 16w+k owns bits 2k+1:2k of word w. The odd bit is stored and read back. The even bit always reads 0.
- R10: Several regions read zero and ignore writes: 0x300–0x3FF (active), 0x800–0xBFF (legacy targets), 0x010, 0xD00–0xEFF, and every offset not listed in these requirements. Writes to these regions leave all stored state unchanged.
- R11: The word at 0xFFE8 reads 0x3B, and writes to it are ignored. The other identification words in 0xFFD0–0xFFFC read 0.
- R12: `irq_req[i]` is 1 exactly when group-1 enable is 1 and interrupt i is both enabled and pending. The line updates one cycle after the write that changes any of these.
- R13: Reset is synchronous and active high. It clears all enable, pending, priority and trigger state, clears group-1 enable, and sets `rdata` to 0.
- R14: `rdata` takes the addressed word on the clock edge at which `rd_en` is sampled high. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 16 | Byte offset; bits 1:0 ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| grp1_en | output | 1 | Global group-1 enable |
| irq_req | output | NUM_IRQ | Per-interrupt pending-and-enabled request |

## Verification
The bench builds the block with NUM_IRQ = 96. This gives two live words in each one-bit array, sixteen live priority words and four live trigger words. With this count the private words, the last live word and the first word past the configured count all fall inside short directed scenarios. The capability word's low field is 2, so it differs from both its minimum and its maximum. Because the arrays are small, the bench can also revisit stored state after each write to an ignored region and confirm that nothing changed.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int ADDR_W     = 16;
    localparam int ID_BITS_M1 = 9;
    localparam int CTL_G1     = 1;
    localparam int CTL_ROUTE  = 4;
    localparam int CTL_ONESEC = 6;
    localparam logic [31:0] PID2_WORD = 32'h0000_003B;

    typedef enum logic [3:0] {
        K_ZERO, K_CTRL, K_TYPE, K_IDENT, K_ONES,
        K_SETEN, K_CLREN, K_SETPD, K_CLRPD,
        K_PRIO, K_CFG, K_PID2
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [7:0] widx;
    } hit_t;

    // Raw region decode; range trimming is done in irqd_decode.
    function automatic hit_t classify(input logic [ADDR_W-1:0] off);
        hit_t h;
        h.kind = K_ZERO;
        h.widx = off[9:2];
        if (off[15:2] == 14'd0)             h.kind = K_CTRL;
        else if (off[15:2] == 14'd1)        h.kind = K_TYPE;
        else if (off[15:2] == 14'd2)        h.kind = K_IDENT;
        else if (off[15:7] == 9'd1)         h.kind = K_ONES;
        else if (off[15:7] == 9'd2) begin h.kind = K_SETEN; h.widx = {3'b0, off[6:2]}; end
        else if (off[15:7] == 9'd3) begin h.kind = K_CLREN; h.widx = {3'b0, off[6:2]}; end
        else if (off[15:7] == 9'd4) begin h.kind = K_SETPD; h.widx = {3'b0, off[6:2]}; end
        else if (off[15:7] == 9'd5) begin h.kind = K_CLRPD; h.widx = {3'b0, off[6:2]}; end
        else if (off[15:10] == 6'd1)        h.kind = K_PRIO;
        else if (off[15:8] == 8'h0C) begin h.kind = K_CFG; h.widx = {2'b0, off[7:2]}; end
        else if (off[15:2] == 14'h3FFA)     h.kind = K_PID2;
        return h;
    endfunction

    function automatic logic [15:0] gather_odd(input logic [31:0] v);
        logic [15:0] r;
        for (int k = 0; k < 16; k++) r[k] = v[2*k+1];
        return r;
    endfunction

    function automatic logic [31:0] spread_odd(input logic [15:0] v);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < 16; k++) r[2*k+1] = v[k];
        return r;
    endfunction

endpackage

// File: rtl/irqd_decode.sv
module irqd_decode
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 96
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit
);
    localparam int BIT_HI  = NUM_IRQ / 32;
    localparam int PRIO_HI = NUM_IRQ / 4;
    localparam int CFG_HI  = NUM_IRQ / 16;

    hit_t raw;

    always_comb begin
        raw = classify(addr);
        hit = raw;
        unique case (raw.kind)
            K_SETEN, K_CLREN, K_SETPD, K_CLRPD: begin
                if (int'(raw.widx) >= 1 && int'(raw.widx) < BIT_HI)
                    hit.widx = raw.widx - 8'd1;
                else
                    hit.kind = K_ZERO;
            end
            K_PRIO: begin
                if (int'(raw.widx) >= 8 && int'(raw.widx) < PRIO_HI)
                    hit.widx = raw.widx - 8'd8;
                else
                    hit.kind = K_ZERO;
            end
            K_CFG: begin
                if (int'(raw.widx) >= 2 && int'(raw.widx) < CFG_HI)
                    hit.widx = raw.widx - 8'd2;
                else
                    hit.kind = K_ZERO;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irqd_bitarr.sv
module irqd_bitarr #(
    parameter int WORDS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_we,
    input  logic                 clr_we,
    input  logic [7:0]           widx,
    input  logic [31:0]          wdata,
    output logic [32*WORDS-1:0]  flat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flat <= '0;
        end else begin
            for (int w = 0; w < WORDS; w++) begin
                if (widx == 8'(w)) begin
                    if (set_we)      flat[32*w +: 32] <= flat[32*w +: 32] | wdata;
                    else if (clr_we) flat[32*w +: 32] <= flat[32*w +: 32] & ~wdata;
                end
            end
        end
    end

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((flat[32*int'($past(widx)) +: 32] & $past(wdata)) == $past(wdata))); // R5
    AST_CLR_LANDS: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((flat[32*int'($past(widx)) +: 32] & $past(wdata)) == 32'd0)); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(flat)); // R10
endmodule

// File: rtl/irqd_attr.sv
module irqd_attr
    import irqd_pkg::*;
#(
    parameter int PWORDS = 16,
    parameter int CWORDS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        prio_we,
    input  logic        cfg_we,
    input  logic [7:0]  widx,
    input  logic [31:0] wdata,
    output logic [31:0] prio_rd,
    output logic [31:0] cfg_rd
);
    logic [32*PWORDS-1:0] pflat;
    logic [16*CWORDS-1:0] cflat;

    always_ff @(posedge clk) begin
        if (rst) begin
            pflat <= '0;
            cflat <= '0;
        end else begin
            for (int w = 0; w < PWORDS; w++)
                if (prio_we && widx == 8'(w)) pflat[32*w +: 32] <= wdata;
            for (int w = 0; w < CWORDS; w++)
                if (cfg_we && widx == 8'(w)) cflat[16*w +: 16] <= gather_odd(wdata);
        end
    end

    assign prio_rd = pflat[32*int'(widx) +: 32];
    assign cfg_rd  = spread_odd(cflat[16*int'(widx) +: 16]);

    AST_PRIO_KEPT: assert property (@(posedge clk) disable iff (rst)
        prio_we |=> (pflat[32*int'($past(widx)) +: 32] == $past(wdata))); // R8
    AST_ATTR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!prio_we && !cfg_we) |=> ($stable(pflat) && $stable(cflat))); // R10
endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
    import irqd_pkg::*;
#(
    parameter int          NUM_IRQ    = 96,
    parameter logic [31:0] IDENT_WORD = 32'h0200_043B
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [15:0]        addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic               grp1_en,
    output logic [NUM_IRQ-1:0] irq_req
);
    localparam int SPI_N  = NUM_IRQ - 32;
    localparam int BWORDS = SPI_N / 32;
    localparam int PWORDS = SPI_N / 4;
    localparam int CWORDS = SPI_N / 16;
    localparam int CAP    = (NUM_IRQ > 1024) ? 1024 : NUM_IRQ;
    localparam logic [31:0] TYPE_WORD =
        32'((CAP / 32) - 1) | (32'(ID_BITS_M1) << 19);

    hit_t hit;
    logic [32*BWORDS-1:0] en_flat, pd_flat;
    logic [31:0] prio_rd, cfg_rd, rd_next, ctrl_word;

    irqd_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (.addr(addr), .hit(hit));

    irqd_bitarr #(.WORDS(BWORDS)) u_en (
        .clk(clk), .rst(rst),
        .set_we(wr_en && hit.kind == K_SETEN),
        .clr_we(wr_en && hit.kind == K_CLREN),
        .widx(hit.widx), .wdata(wdata), .flat(en_flat));

    irqd_bitarr #(.WORDS(BWORDS)) u_pd (
        .clk(clk), .rst(rst),
        .set_we(wr_en && hit.kind == K_SETPD),
        .clr_we(wr_en && hit.kind == K_CLRPD),
        .widx(hit.widx), .wdata(wdata), .flat(pd_flat));

    irqd_attr #(.PWORDS(PWORDS), .CWORDS(CWORDS)) u_attr (
        .clk(clk), .rst(rst),
        .prio_we(wr_en && hit.kind == K_PRIO),
        .cfg_we(wr_en && hit.kind == K_CFG),
        .widx(hit.widx), .wdata(wdata),
        .prio_rd(prio_rd), .cfg_rd(cfg_rd));

    always_ff @(posedge clk) begin
        if (rst)                            grp1_en <= 1'b0;
        else if (wr_en && hit.kind == K_CTRL) grp1_en <= wdata[CTL_G1];
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTL_G1]     = grp1_en;
        ctrl_word[CTL_ROUTE]  = 1'b1;
        ctrl_word[CTL_ONESEC] = 1'b1;
    end

    always_comb begin
        unique case (hit.kind)
            K_CTRL:           rd_next = ctrl_word;
            K_TYPE:           rd_next = TYPE_WORD;
            K_IDENT:          rd_next = IDENT_WORD;
            K_ONES:           rd_next = '1;
            K_SETEN, K_CLREN: rd_next = en_flat[32*int'(hit.widx) +: 32];
            K_SETPD, K_CLRPD: rd_next = pd_flat[32*int'(hit.widx) +: 32];
            K_PRIO:           rd_next = prio_rd;
            K_CFG:            rd_next = cfg_rd;
            K_PID2:           rd_next = PID2_WORD;
            default:          rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end

    assign irq_req = {en_flat & pd_flat & {SPI_N{grp1_en}}, 32'b0};

    AST_CTRL_FIXED: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[15:2] == 14'd0) |=> (rdata[6] && rdata[4] && !rdata[0])); // R1
    AST_GROUP_ONES: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[15:7] == 9'd1) |=> (rdata == 32'hFFFF_FFFF)); // R4
    AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !grp1_en |-> (irq_req == '0)); // R12
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R14
endmodule

// File: tb/sim_irq_dist_regs.sv
`timescale 1ns/1ps
module sim_irq_dist_regs;
    localparam int N = 96;
    localparam logic [31:0] IDW = 32'h0200_043B;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic grp1_en;
    logic [N-1:0] irq_req;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_dist_regs #(.NUM_IRQ(N), .IDENT_WORD(IDW)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .grp1_en(grp1_en), .irq_req(irq_req));

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic rd_chk(string tag, logic [15:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        check("R13 rdata", rdata, 0);
        check("R13 grp1", grp1_en, 0);
        check("R12 req", irq_req, 0);
        rd_chk("R1 ctrl reset", 16'h000, 32'h50);
        rd_chk("R2 type", 16'h004, 32'h0048_0002);
        rd_chk("R13 enable", 16'h104, 0);
        rd_chk("R13 prio", 16'h420, 0);
    endtask

    task automatic t_ctrl();
        wr(16'h000, 32'h3);
        rd_chk("R1 g1 set g0 ignored", 16'h000, 32'h52);
        check("R1 grp1_en", grp1_en, 1);
        wr(16'h000, 32'h0);
        rd_chk("R1 fixed bits stay", 16'h000, 32'h50);
        check("R1 grp1_en off", grp1_en, 0);
    endtask

    task automatic t_fixed();
        wr(16'h008, 32'h0);
        rd_chk("R3 ident", 16'h008, IDW);
        wr(16'h004, 32'hFFFF_FFFF);
        rd_chk("R2 type write ignored", 16'h004, 32'h0048_0002);
        wr(16'h084, 32'h0);
        rd_chk("R4 group first", 16'h084, 32'hFFFF_FFFF);
        rd_chk("R4 group last", 16'h0FC, 32'hFFFF_FFFF);
    endtask

    task automatic t_enable();
        wr(16'h104, 32'hA5A5_0F0F);
        rd_chk("R5 set", 16'h104, 32'hA5A5_0F0F);
        rd_chk("R5 clear window reads", 16'h184, 32'hA5A5_0F0F);
        wr(16'h184, 32'h0000_000F);
        rd_chk("R5 clear", 16'h104, 32'hA5A5_0F00);
        wr(16'h104, 32'h0);
        rd_chk("R5 zero write no effect", 16'h104, 32'hA5A5_0F00);
        wr(16'h108, 32'h8000_0001);
        rd_chk("R5 last word", 16'h188, 32'h8000_0001);
    endtask

    task automatic t_pend();
        logic [N-1:0] one40;
        one40 = '0; one40[40] = 1'b1;
        wr(16'h204, 32'h0000_0100);
        rd_chk("R6 set pending", 16'h284, 32'h0000_0100);
        check("R12 gated by grp1", irq_req, 0);
        wr(16'h000, 32'h2);
        check("R12 request", irq_req, one40);
        wr(16'h284, 32'h0000_0100);
        rd_chk("R6 clear pending", 16'h204, 0);
        check("R12 drops on clear", irq_req, 0);
        wr(16'h204, 32'h0000_0100);
        check("R12 back", irq_req, one40);
        wr(16'h184, 32'h0000_0100);
        check("R12 drops on disable", irq_req, 0);
        wr(16'h000, 32'h0);
    endtask

    task automatic t_private();
        wr(16'h000, 32'h2);
        wr(16'h100, 32'hFFFF_FFFF);
        rd_chk("R7 priv enable", 16'h100, 0);
        wr(16'h200, 32'hFFFF_FFFF);
        rd_chk("R7 priv pending", 16'h280, 0);
        check("R7 low requests", irq_req[31:0], 0);
        wr(16'h000, 32'h0);
        wr(16'h10C, 32'hFFFF_FFFF);
        rd_chk("R7 past count bits", 16'h10C, 0);
        wr(16'h400, 32'hFFFF_FFFF);
        rd_chk("R7 priv prio", 16'h400, 0);
        wr(16'h460, 32'hFFFF_FFFF);
        rd_chk("R7 past count prio", 16'h460, 0);
        wr(16'hC04, 32'hFFFF_FFFF);
        rd_chk("R7 priv cfg", 16'hC04, 0);
        wr(16'hC18, 32'hFFFF_FFFF);
        rd_chk("R7 past count cfg", 16'hC18, 0);
    endtask

    task automatic t_prio_cfg();
        wr(16'h420, 32'h1122_3344);
        rd_chk("R8 prio", 16'h420, 32'h1122_3344);
        wr(16'h45C, 32'hDEAD_BEEF);
        rd_chk("R8 prio last", 16'h45C, 32'hDEAD_BEEF);
        rd_chk("R8 prio other kept", 16'h420, 32'h1122_3344);
        wr(16'hC08, 32'hFFFF_FFFF);
        rd_chk("R9 cfg odd only", 16'hC08, 32'hAAAA_AAAA);
        wr(16'hC14, 32'h0000_0003);
        rd_chk("R9 cfg last", 16'hC14, 32'h0000_0002);
    endtask

    task automatic t_raz();
        wr(16'h384, 32'hFFFF_FFFF);
        rd_chk("R10 active clear harmless", 16'h104, 32'hA5A5_0E00);
        rd_chk("R10 active reads zero", 16'h384, 0);
        wr(16'h304, 32'hFFFF_FFFF);
        rd_chk("R10 active set", 16'h304, 0);
        wr(16'h820, 32'hFFFF_FFFF);
        rd_chk("R10 targets", 16'h820, 0);
        wr(16'hD04, 32'hFFFF_FFFF);
        rd_chk("R10 grp modifier", 16'hD04, 0);
        rd_chk("R10 status", 16'h010, 0);
        wr(16'h2000, 32'hFFFF_FFFF);
        rd_chk("R10 unmapped", 16'h2000, 0);
        rd_chk("R10 state intact", 16'h108, 32'h8000_0001);
        rd_chk("R10 prio intact", 16'h420, 32'h1122_3344);
    endtask

    task automatic t_ids();
        rd_chk("R11 pid2", 16'hFFE8, 32'h3B);
        wr(16'hFFE8, 32'h0);
        rd_chk("R11 pid2 after write", 16'hFFE8, 32'h3B);
        rd_chk("R11 other id", 16'hFFE0, 0);
        rd_chk("R11 id base", 16'hFFD0, 0);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        rd(16'h004, v);
        repeat (3) @(negedge clk);
        check("R14 rdata holds", rdata, 32'h0048_0002);
        wr(16'h000, 32'h2);
        check("R14 write does not load rdata", rdata, 32'h0048_0002);
        wr(16'h000, 32'h0);
    endtask

    task automatic t_reset_again();
        wr(16'h000, 32'h2);
        do_reset();
        check("R13 grp1 cleared", grp1_en, 0);
        rd_chk("R13 enable cleared", 16'h104, 0);
        rd_chk("R13 pending cleared", 16'h204, 0);
        rd_chk("R13 prio cleared", 16'h45C, 0);
        rd_chk("R13 cfg cleared", 16'hC08, 0);
        rd_chk("R13 ctrl", 16'h000, 32'h50);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_fixed();
        t_enable();
        t_pend();
        t_private();
        t_prio_cfg();
        t_raz();
        t_ids();
        t_hold();
        t_reset_again();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule